// File: doc/BRIEF.md
# SDRAM Write-Back Burst Command Sequencer

This block sits on the controller side of a synchronous DRAM port and carries out one fixed four-beat burst write, the kind used when a dirty cache line is written back. A caller presents a bank, a row, a starting column and four data words with a one-cycle start request. The sequencer then opens the row, issues four column writes with their data, and ends the burst with a write that also closes the row through auto-precharge.

Because the bank precharges on its own after that last write, nothing may be sent to the bank until it is idle again. The sequencer therefore waits out a write-recovery interval (one or two cycles, picked by a single configuration bit) and then a precharge interval (one to four cycles, from a two-bit field), driving NOP on the pins throughout and holding its busy flag. When the bank is free the busy flag drops and a one-cycle done pulse is given. All request fields and configuration are captured at the moment the request is accepted.

Top module: `sdram_wb_burst_seq`

## Requirements
- R1: After reset the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the data output enable is low, and busy and done are both low.
- R2: A start request sampled while not busy causes, in the next cycle, an activate command ({cs_n,ras_n,cas_n,we_n} = 0011) with the bank pins equal to the requested bank and the address pins equal to the requested row; busy is high from that cycle.
- R3: The four cycles after the activate each carry a write command (0100) on the requested bank, with address bits [COL_W-1:0] equal to the start column plus 0, 1, 2 and 3, wrapping modulo 2**COL_W.
- R4: Address bit 10 is high on the fourth write (auto-precharge) and low on the first three writes; all address bits other than the column field and bit 10 are zero during writes.
- R5: During the k-th write (k = 0..3) the data output equals wdata_i[k*DATA_W +: DATA_W] and the output enable is high; the output enable is low in every other cycle.
- R6: After the fourth write the sequencer drives NOP for the write-recovery interval (1 cycle when rwl_long_i was 0 at acceptance, 2 cycles when it was 1) and then for the precharge interval (pc_wait_i + 1 cycles); busy stays high over both intervals.
- R7: In the first cycle after the precharge interval busy is low and done is high for exactly one cycle; a new start may be accepted in that cycle.
- R8: A start request sampled while busy is ignored: no activate is issued and the running burst continues unchanged.
- R9: Bank, row, column, data and both configuration fields are captured when a request is accepted; changing these inputs while busy has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle burst request, taken only when not busy |
| bank_i | input | BANK_W | Target bank |
| row_i | input | ADDR_W | Row to open |
| col_i | input | COL_W | First column of the burst |
| wdata_i | input | 4*DATA_W | Four data words, word k in bits [k*DATA_W +: DATA_W] |
| rwl_long_i | input | 1 | Write-recovery length select: 0 gives 1 cycle, 1 gives 2 cycles |
| pc_wait_i | input | TPC_W | Precharge wait minus one |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank address |
| sd_addr_o | output | ADDR_W | Row or column address; bit 10 flags auto-precharge |
| sd_dq_o | output | DATA_W | Write data |
| sd_dq_oe_o | output | 1 | Data output enable |
| busy_o | output | 1 | Bank in use, including recovery and precharge waits |
| done_o | output | 1 | One-cycle pulse when the bank is free again |

## Verification
The hardest cases to reach are a start request landing in the last precharge wait cycle, which must be ignored, and one landing in the done cycle, which must be taken at once. The stimulus reaches both by counting the exact burst length from the chosen configuration: one burst raises start with altered address, data and configuration on every busy cycle up to and including the last wait, and the next burst is requested in the very cycle its predecessor reports done. Column wrap at the top of the column range and the shortest and longest wait settings are driven as separate bursts.

// File: rtl/sdram_wb_pkg.sv
// Shared types for the write-back burst sequencer.
// Assumes active-low command pins in the order cs_n, ras_n, cas_n, we_n.
package sdram_wb_pkg;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = 2;
    localparam int AP_BIT    = 10;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ACT  = 3'd1,
        PH_WR   = 3'd2,
        PH_RWL  = 3'd3,
        PH_PC   = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = 4'b0111;
    localparam sd_cmd_t CMD_ACT = 4'b0011;
    localparam sd_cmd_t CMD_WR  = 4'b0100;

endpackage

// File: rtl/wb_burst_fsm.sv
// Phase controller for one write-back burst.
// Walks idle -> activate -> four write beats -> write-recovery wait ->
// precharge wait -> idle. A start is honoured only in idle. The wait
// lengths are taken from inputs that the parent holds stable while busy.
module wb_burst_fsm
    import sdram_wb_pkg::*;
#(
    parameter int TPC_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                rwl_long_i,
    input  logic [TPC_W-1:0]    pc_wait_i,
    output logic                accept_o,
    output phase_e              phase_o,
    output logic [BEAT_W-1:0]   beat_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam int WCNT_W = (TPC_W > 1) ? TPC_W : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    phase_e              phase_q, phase_d;
    logic [BEAT_W-1:0]   beat_q, beat_d;
    logic [WCNT_W-1:0]   wcnt_q, wcnt_d;
    logic                done_q, done_d;

    assign accept_o = (phase_q == PH_IDLE) && start_i;

    // Next-phase, beat and wait-counter selection.
    always_comb begin
        phase_d = phase_q;
        beat_d  = beat_q;
        wcnt_d  = wcnt_q;
        done_d  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d = PH_ACT;
                end
            end
            PH_ACT: begin
                phase_d = PH_WR;
                beat_d  = '0;
            end
            PH_WR: begin
                if (beat_q == LAST_BEAT) begin
                    phase_d = PH_RWL;
                    beat_d  = '0;
                    wcnt_d  = rwl_long_i ? WCNT_W'(1) : '0;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            PH_RWL: begin
                if (wcnt_q == '0) begin
                    phase_d = PH_PC;
                    wcnt_d  = WCNT_W'(pc_wait_i);
                end else begin
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            PH_PC: begin
                if (wcnt_q == '0) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end else begin
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                beat_d  = '0;
                wcnt_d  = '0;
            end
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            beat_q  <= '0;
            wcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            beat_q  <= beat_d;
            wcnt_q  <= wcnt_d;
            done_q  <= done_d;
        end
    end

    assign phase_o = phase_q;
    assign beat_o  = beat_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign done_o  = done_q;

    AST_LAST_BEAT_TO_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WR && beat_q == LAST_BEAT) |=> (phase_q == PH_RWL)) else $error("last beat must enter recovery"); // R6
    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q != PH_ACT)) else $error("activate while busy"); // R8
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R7
    AST_DONE_ONLY_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase_q == PH_IDLE)) else $error("done while busy"); // R7

endmodule

// File: rtl/wb_cmd_encode.sv
// Pin encoder for the write-back burst.
// Turns the current phase and beat into command pins, bank, address and
// data. Assumes COL_W <= 10 and ADDR_W > 10 so the column field and the
// auto-precharge bit do not overlap. Purely combinational.
module wb_cmd_encode
    import sdram_wb_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32
) (
    input  phase_e                          phase_i,
    input  logic [BEAT_W-1:0]               beat_i,
    input  logic [BANK_W-1:0]               bank_i,
    input  logic [ADDR_W-1:0]               row_i,
    input  logic [COL_W-1:0]                col_i,
    input  logic [BURST_LEN*DATA_W-1:0]     wdata_i,
    output sd_cmd_t                         cmd_o,
    output logic [BANK_W-1:0]               ba_o,
    output logic [ADDR_W-1:0]               addr_o,
    output logic [DATA_W-1:0]               dq_o,
    output logic                            dq_oe_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    logic [DATA_W-1:0] word [BURST_LEN];
    logic [COL_W-1:0]  col_now;

    // Split the packed data into one word per beat.
    for (genvar k = 0; k < BURST_LEN; k++) begin : g_word
        assign word[k] = wdata_i[k*DATA_W +: DATA_W];
    end

    assign col_now = col_i + COL_W'(beat_i);

    // Command, address and data selection per phase.
    always_comb begin
        cmd_o   = CMD_NOP;
        ba_o    = bank_i;
        addr_o  = '0;
        dq_o    = '0;
        dq_oe_o = 1'b0;
        case (phase_i)
            PH_ACT: begin
                cmd_o  = CMD_ACT;
                addr_o = row_i;
            end
            PH_WR: begin
                cmd_o                  = CMD_WR;
                addr_o[COL_W-1:0]      = col_now;
                addr_o[AP_BIT]         = (beat_i == LAST_BEAT);
                dq_o                   = word[beat_i];
                dq_oe_o                = 1'b1;
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_wb_burst_seq.sv
// Top of the write-back burst sequencer.
// Captures the request and configuration on acceptance, runs the phase
// controller and drives the SDRAM pins through the encoder. Assumes the
// caller keeps start_i to one cycle; extra starts while busy are dropped.
module sdram_wb_burst_seq
    import sdram_wb_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32,
    parameter int TPC_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [BANK_W-1:0]           bank_i,
    input  logic [ADDR_W-1:0]           row_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [4*DATA_W-1:0]         wdata_i,
    input  logic                        rwl_long_i,
    input  logic [TPC_W-1:0]            pc_wait_i,
    output logic                        sd_cs_n_o,
    output logic                        sd_ras_n_o,
    output logic                        sd_cas_n_o,
    output logic                        sd_we_n_o,
    output logic [BANK_W-1:0]           sd_ba_o,
    output logic [ADDR_W-1:0]           sd_addr_o,
    output logic [DATA_W-1:0]           sd_dq_o,
    output logic                        sd_dq_oe_o,
    output logic                        busy_o,
    output logic                        done_o
);

    localparam int DBUS_W = BURST_LEN * DATA_W;

    logic                accept;
    phase_e              phase;
    logic [BEAT_W-1:0]   beat;
    sd_cmd_t             cmd;

    logic [BANK_W-1:0]   bank_q;
    logic [ADDR_W-1:0]   row_q;
    logic [COL_W-1:0]    col_q;
    logic [DBUS_W-1:0]   data_q;
    logic                rwl_long_q;
    logic [TPC_W-1:0]    pc_wait_q;

    // Capture request fields and configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= '0;
            row_q      <= '0;
            col_q      <= '0;
            data_q     <= '0;
            rwl_long_q <= 1'b0;
            pc_wait_q  <= '0;
        end else if (accept) begin
            bank_q     <= bank_i;
            row_q      <= row_i;
            col_q      <= col_i;
            data_q     <= wdata_i;
            rwl_long_q <= rwl_long_i;
            pc_wait_q  <= pc_wait_i;
        end
    end

    wb_burst_fsm #(
        .TPC_W (TPC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rwl_long_i (rwl_long_q),
        .pc_wait_i  (pc_wait_q),
        .accept_o   (accept),
        .phase_o    (phase),
        .beat_o     (beat),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    wb_cmd_encode #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_enc (
        .phase_i (phase),
        .beat_i  (beat),
        .bank_i  (bank_q),
        .row_i   (row_q),
        .col_i   (col_q),
        .wdata_i (data_q),
        .cmd_o   (cmd),
        .ba_o    (sd_ba_o),
        .addr_o  (sd_addr_o),
        .dq_o    (sd_dq_o),
        .dq_oe_o (sd_dq_oe_o)
    );

    assign sd_cs_n_o  = cmd.cs_n;
    assign sd_ras_n_o = cmd.ras_n;
    assign sd_cas_n_o = cmd.cas_n;
    assign sd_we_n_o  = cmd.we_n;

    AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (cmd == CMD_ACT && busy_o)) else $error("no activate after start"); // R2
    AST_WRITE_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> (cmd == CMD_WR && !sd_addr_o[AP_BIT])) else $error("activate not followed by plain write"); // R3
    AST_AP_WRITE_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && sd_addr_o[AP_BIT]) |=> (cmd == CMD_NOP && busy_o)) else $error("command after auto-precharge write"); // R4
    AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe_o |-> (cmd == CMD_WR)) else $error("data driven without write"); // R5
    AST_DONE_FREES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))) else $error("done without preceding busy"); // R7
    AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cmd == CMD_NOP && !sd_dq_oe_o)) else $error("pins active while idle"); // R1

endmodule

// File: tb/sdram_wb_burst_seq_bench.sv
// Scoreboard bench: the driver pushes one expected pin snapshot per cycle,
// the monitor pops and compares a quarter period after each rising edge.
module sdram_wb_burst_seq_bench;

    localparam int BANK_W = 2;
    localparam int ADDR_W = 13;
    localparam int COL_W  = 9;
    localparam int DATA_W = 32;
    localparam int TPC_W  = 2;

    typedef struct {
        logic [3:0]         cmd;
        logic [BANK_W-1:0]  ba;
        logic [ADDR_W-1:0]  addr;
        logic               chk_addr;
        logic               oe;
        logic [DATA_W-1:0]  dq;
        logic               busy;
        logic               done;
        string              tag;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic [BANK_W-1:0]      bank_i = '0;
    logic [ADDR_W-1:0]      row_i = '0;
    logic [COL_W-1:0]       col_i = '0;
    logic [4*DATA_W-1:0]    wdata_i = '0;
    logic                   rwl_long_i = 1'b0;
    logic [TPC_W-1:0]       pc_wait_i = '0;
    logic                   sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
    logic [BANK_W-1:0]      sd_ba_o;
    logic [ADDR_W-1:0]      sd_addr_o;
    logic [DATA_W-1:0]      sd_dq_o;
    logic                   sd_dq_oe_o;
    logic                   busy_o, done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    sdram_wb_burst_seq #(
        .BANK_W (BANK_W), .ADDR_W (ADDR_W), .COL_W (COL_W),
        .DATA_W (DATA_W), .TPC_W (TPC_W)
    ) u_sdram_wb_burst_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .bank_i (bank_i), .row_i (row_i), .col_i (col_i), .wdata_i (wdata_i),
        .rwl_long_i (rwl_long_i), .pc_wait_i (pc_wait_i),
        .sd_cs_n_o (sd_cs_n_o), .sd_ras_n_o (sd_ras_n_o),
        .sd_cas_n_o (sd_cas_n_o), .sd_we_n_o (sd_we_n_o),
        .sd_ba_o (sd_ba_o), .sd_addr_o (sd_addr_o), .sd_dq_o (sd_dq_o),
        .sd_dq_oe_o (sd_dq_oe_o), .busy_o (busy_o), .done_o (done_o)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
    endfunction

    // Compare the pins against one expected snapshot.
    task automatic compare(input exp_t e);
        logic bad;
        bad = (pins() !== e.cmd) || (busy_o !== e.busy) || (done_o !== e.done) ||
              (sd_dq_oe_o !== e.oe);
        if (e.chk_addr) bad = bad || (sd_ba_o !== e.ba) || (sd_addr_o !== e.addr);
        if (e.oe) bad = bad || (sd_dq_o !== e.dq);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: got cmd=%b ba=%h addr=%h oe=%b dq=%h busy=%b done=%b, expected cmd=%b ba=%h addr=%h oe=%b dq=%h busy=%b done=%b",
                     e.tag, pins(), sd_ba_o, sd_addr_o, sd_dq_oe_o, sd_dq_o, busy_o, done_o,
                     e.cmd, e.ba, e.addr, e.oe, e.dq, e.busy, e.done);
        end
    endtask

    // Monitor: pops one expected item per cycle while the queue holds any.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected at most 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic exp_t mk(input logic [3:0] cmd, input logic busy, input logic done,
                                input string tag);
        exp_t e;
        e.cmd = cmd; e.ba = '0; e.addr = '0; e.chk_addr = 1'b0; e.oe = 1'b0;
        e.dq = '0; e.busy = busy; e.done = done; e.tag = tag;
        return e;
    endfunction

    // Driver: requests one burst, pushes its expected cycles, optionally
    // raises start with altered inputs on every busy cycle (R8, R9).
    task automatic burst(input logic [BANK_W-1:0] bk, input logic [ADDR_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [4*DATA_W-1:0] data,
                         input logic rwl, input logic [TPC_W-1:0] pcw, input bit spam);
        exp_t e;
        int   trwl_n;
        int   tpc_n;
        int   len;
        string sfx;
        sfx = spam ? " R8 R9" : "";
        trwl_n = rwl ? 2 : 1;
        tpc_n  = int'(pcw) + 1;
        len    = 5 + trwl_n + tpc_n;
        @(negedge clk);
        start_i = 1'b1; bank_i = bk; row_i = row; col_i = col; wdata_i = data;
        rwl_long_i = rwl; pc_wait_i = pcw;
        e = mk(4'b0011, 1'b1, 1'b0, {"R2 activate", sfx});
        e.chk_addr = 1'b1; e.ba = bk; e.addr = row;
        q.push_back(e);
        for (int k = 0; k < 4; k++) begin
            e = mk(4'b0100, 1'b1, 1'b0, {"R3 R4 R5 write beat", sfx});
            e.chk_addr = 1'b1; e.ba = bk;
            e.addr = '0;
            e.addr[COL_W-1:0] = col + COL_W'(k);
            e.addr[10] = (k == 3);
            e.oe = 1'b1;
            e.dq = data[k*DATA_W +: DATA_W];
            q.push_back(e);
        end
        for (int k = 0; k < trwl_n; k++) q.push_back(mk(4'b0111, 1'b1, 1'b0, {"R6 recovery wait", sfx}));
        for (int k = 0; k < tpc_n; k++)  q.push_back(mk(4'b0111, 1'b1, 1'b0, {"R6 precharge wait", sfx}));
        q.push_back(mk(4'b0111, 1'b0, 1'b1, {"R7 done pulse", sfx}));
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (spam) begin
                start_i = 1'b1; bank_i = ~bk; row_i = row ^ ADDR_W'(k * 37);
                col_i = col + COL_W'(100); wdata_i = ~data;
                rwl_long_i = ~rwl; pc_wait_i = pcw + TPC_W'(k);
            end else begin
                start_i = 1'b0;
            end
        end
    endtask

    task automatic drain();
        @(negedge clk);
        start_i = 1'b0;
        q.push_back(mk(4'b0111, 1'b0, 1'b0, "R7 done falls after one cycle"));
        while (q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        q.push_back(mk(4'b0111, 1'b0, 1'b0, "R1 reset state"));
        compare(q.pop_front());
        @(negedge clk);
        rst_n = 1'b1;

        // Shortest waits.
        burst(2'd1, 13'h0ABC, 9'd16, {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001},
              1'b0, 2'd0, 1'b0);
        drain();
        // Longest waits with column wrap.
        burst(2'd3, 13'h1F0F, 9'd510, {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0123_4567, 32'h89AB_CDEF},
              1'b1, 2'd3, 1'b0);
        drain();
        // Start held high with altered inputs during the whole busy time.
        burst(2'd2, 13'h0155, 9'd200, {32'hA5A5_0000, 32'h5A5A_1111, 32'hFFFF_2222, 32'h0000_3333},
              1'b1, 2'd1, 1'b1);
        // Next burst requested in the done cycle of the previous one.
        burst(2'd0, 13'h1234, 9'd7, {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1357_9BDF, 32'h2468_ACE0},
              1'b0, 2'd2, 1'b0);
        drain();

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule